// File: doc/BRIEF.md
# Key-Protected Stop Control Register

This block is a single byte-wide control register on a simple CPU bus. It holds two live bits: a stop-disable bit and a clock-source bit. Software cannot change them with an ordinary write. It must first write a key value to the register address, and then make the very next write to that address carry the new bit values. The key write alone changes nothing. An interrupt acknowledge between the two writes cancels the sequence, and so does a write to any other address. In either case the data write is dropped.

The two stored bits drive two outputs.

- The stop-disable bit gates a raw stop-instruction request before it reaches the stop-mode enable output.
- The clock-source bit, together with a system clock select input, decides whether the watchdog must time oscillator stabilisation when stop mode ends.

Reads are always allowed. Software can therefore read the register back and confirm that a protected write took effect.

Top module: `skp_top`

## Requirements
- R1: After reset both stored bits are 0, no unlock is pending, and `rdata_o` is 0.
- R2: A write of the key value 0x55 to address 0x62 with no unlock pending arms the unlock and leaves both stored bits unchanged.
- R3: The first write to 0x62 after an armed unlock loads stored bit 0 (stop disable) from data bit 0 and stored bit 1 (external clock) from data bit 1. Data bits 7:2 are ignored.
- R4: A write to 0x62 with no unlock pending changes no stored bit. A 0x55 written this way only arms the unlock.
- R5: Any write to 0x62 consumes the unlock, so a second data write needs a fresh key. A 0x55 written as the data write loads bits 01 and does not re-arm.
- R6: An `irq_ack_i` pulse cancels a pending unlock. An `irq_ack_i` in the same cycle as the data write drops that write. In both cases the stored bits are unchanged.
- R7: A write to any address other than 0x62 cancels a pending unlock, so the next write to 0x62 is ignored.
- R8: A read strobe at 0x62 returns {6'b0, external clock bit, stop disable bit} on `rdata_o` in the next cycle. A read at any other address, and any cycle with no read, gives 0.
- R9: `stop_en_o` follows `stop_req_i` while stop disable is 0, and is 0 while stop disable is 1.
- R10: `wdt_wake_o` is 1 while the external clock bit is 0. While that bit is 1, `wdt_wake_o` equals `sys_clk_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Bus byte address |
| wdata_i | input | DATA_W | Bus write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, valid the cycle after `re_i` |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| sys_clk_sel_i | input | 1 | System clock select |
| stop_req_i | input | 1 | Raw stop-instruction request |
| stop_en_o | output | 1 | Gated stop-mode enable |
| wdt_wake_o | output | 1 | Watchdog must time stabilisation at stop-mode exit |

## Verification
The bench builds the block with its default parameters: 8-bit address and data, register address 0x62, key 0x55. With this build, the key value's own low bits (01) are a legal data pattern, so the case where a key is written as the data write is reachable. The same build also reaches the case where an interrupt and a data write land in the same cycle. A scoreboard queues the expected read-back values and compares them against `rdata_o`. Every unlock-cancelling path is followed by such a read-back.

// File: rtl/skp_pkg.sv
package skp_pkg;
  typedef struct packed {
    logic ext_clk;   // 1: external clock, oscillator off
    logic stp_off;   // 1: stop request blocked
  } stop_cfg_t;

  localparam int unsigned CFG_W = $bits(stop_cfg_t);
endpackage

// File: rtl/skp_unlock.sv
module skp_unlock #(
  parameter int unsigned        DATA_W = 8,
  parameter logic [DATA_W-1:0]  KEY    = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic              wr_miss_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_ack_i,
  output logic              armed_o,
  output logic              load_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (irq_ack_i || wr_miss_i)
      armed_d = 1'b0;
    else if (wr_hit_i)
      armed_d = armed_q ? 1'b0 : (wdata_i == KEY);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;

  assign armed_o = armed_q;
  assign load_o  = wr_hit_i & armed_q & ~irq_ack_i;

  AST_IRQ_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> !armed_q); // R6
  AST_MISS_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_miss_i |=> !armed_q); // R7
  AST_ARM_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && armed_q) |=> !armed_q); // R5
endmodule

// File: rtl/skp_cfg_store.sv
module skp_cfg_store
  import skp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_hit_i,
  output stop_cfg_t         cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CFG_W;

  stop_cfg_t         cfg_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= stop_cfg_t'(wdata_i[CFG_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       rdata_q <= '0;
    else if (rd_hit_i) rdata_q <= {{PAD_W{1'b0}}, cfg_q};
    else               rdata_q <= '0;

  assign cfg_o   = cfg_q;
  assign rdata_o = rdata_q;

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q)); // R4
  AST_RD_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_i |=> rdata_o == {{PAD_W{1'b0}}, $past(cfg_q)}); // R8
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit_i |=> rdata_o == '0); // R8
endmodule

// File: rtl/skp_top.sv
module skp_top
  import skp_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h62,
  parameter logic [DATA_W-1:0] KEY     = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              irq_ack_i,
  input  logic              sys_clk_sel_i,
  input  logic              stop_req_i,
  output logic              stop_en_o,
  output logic              wdt_wake_o
);
  logic      hit, wr_hit, wr_miss, rd_hit;
  logic      armed, load;
  stop_cfg_t cfg;

  assign hit     = (addr_i == REG_ADDR);
  assign wr_hit  = we_i & hit;
  assign wr_miss = we_i & ~hit;
  assign rd_hit  = re_i & hit;

  skp_unlock #(.DATA_W(DATA_W), .KEY(KEY)) u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .wr_miss_i(wr_miss),
    .wdata_i  (wdata_i),
    .irq_ack_i(irq_ack_i),
    .armed_o  (armed),
    .load_o   (load)
  );

  skp_cfg_store #(.DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .wdata_i (wdata_i),
    .rd_hit_i(rd_hit),
    .cfg_o   (cfg),
    .rdata_o (rdata_o)
  );

  assign stop_en_o  = stop_req_i & ~cfg.stp_off;
  // oscillator mode always needs stabilisation timing
  assign wdt_wake_o = ~cfg.ext_clk | sys_clk_sel_i;

  AST_UPDATE_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !armed) |=> $stable(cfg)); // R2
  AST_IRQ_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && irq_ack_i) |=> $stable(cfg)); // R6
  AST_STOP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.stp_off |-> !stop_en_o); // R9
  AST_WDT_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.ext_clk |-> wdt_wake_o); // R10
endmodule

// File: tb/skp_top_bench.sv
`timescale 1ns/1ps
module skp_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       we = 1'b0, re = 1'b0, irq = 1'b0, sys_sel = 1'b0, stop_req = 1'b0;
  logic [7:0] rdata;
  logic       stop_en, wdt_wake;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];
  logic re_seen = 1'b0;

  always #2 clk = ~clk;

  skp_top u_skp_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .irq_ack_i(irq),
    .sys_clk_sel_i(sys_sel), .stop_req_i(stop_req),
    .stop_en_o(stop_en), .wdt_wake_o(wdt_wake)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: the read strobe seen at a rising edge yields data by the next falling edge
  always @(posedge clk) re_seen <= re;
  always @(negedge clk) begin
    if (re_seen) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected read data %02h expected none", rdata);
      end else begin
        e = exp_q.pop_front();
        check(e.req, rdata, e.val);
      end
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [7:0] d, logic with_irq = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; irq = with_irq;
    @(negedge clk);
    we = 1'b0; irq = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a; re = 1'b1;
    exp_q.push_back('{val: exp, req: req});
    @(negedge clk);
    re = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_outs(logic req_in, logic sel, logic exp_stop, logic exp_wdt, string req);
    @(negedge clk);
    stop_req = req_in; sys_sel = sel;
    #1;
    check({req, "/stop_en"}, {7'b0, stop_en}, {7'b0, exp_stop});
    check({req, "/wdt_wake"}, {7'b0, wdt_wake}, {7'b0, exp_wdt});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 rdata", rdata, 8'h00);
    rst_n = 1'b1;
    bus_rd(8'h62, 8'h00, "R1 read");
    chk_outs(1'b1, 1'b0, 1'b1, 1'b1, "R1");

    bus_wr(8'h62, 8'h55);                      // R2 arm
    bus_rd(8'h62, 8'h00, "R2 key no change");
    bus_wr(8'h62, 8'hFF);                      // R3 data
    bus_rd(8'h62, 8'h03, "R3 load low bits");
    chk_outs(1'b1, 1'b0, 1'b0, 1'b0, "R9/R10 blocked, ext sel0");
    chk_outs(1'b0, 1'b1, 1'b0, 1'b1, "R10 ext sel1");

    bus_wr(8'h62, 8'h00);                      // R4 no key
    bus_rd(8'h62, 8'h03, "R4 unkeyed ignored");

    bus_wr(8'h62, 8'h55);
    bus_wr(8'h62, 8'h02);
    bus_rd(8'h62, 8'h02, "R3 load 02");
    bus_wr(8'h62, 8'h01);                      // R5 unlock consumed
    bus_rd(8'h62, 8'h02, "R5 second write ignored");
    chk_outs(1'b1, 1'b0, 1'b1, 1'b0, "R9 pass, R10 ext sel0");

    bus_wr(8'h62, 8'h55);
    pulse_irq();
    bus_wr(8'h62, 8'h01);
    bus_rd(8'h62, 8'h02, "R6 irq between");

    bus_wr(8'h62, 8'h55);
    bus_wr(8'h62, 8'h01, 1'b1);
    bus_rd(8'h62, 8'h02, "R6 irq same cycle");

    bus_wr(8'h62, 8'h55);
    bus_wr(8'h10, 8'h00);
    bus_wr(8'h62, 8'h01);
    bus_rd(8'h62, 8'h02, "R7 other address");

    bus_wr(8'h62, 8'h55);
    bus_wr(8'h62, 8'h55);                      // key as data
    bus_rd(8'h62, 8'h01, "R5 key as data");
    bus_wr(8'h62, 8'h00);
    bus_rd(8'h62, 8'h01, "R5 no re-arm");
    chk_outs(1'b1, 1'b0, 1'b0, 1'b1, "R10 osc sel0");
    chk_outs(1'b0, 1'b1, 1'b0, 1'b1, "R9 idle, R10 osc sel1");

    bus_rd(8'h20, 8'h00, "R8 other address read");
    @(negedge clk);
    check("R8 idle rdata", rdata, 8'h00);
    check("R8 queue drained", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule